// File: doc/BRIEF.md
# Three-Stage Master Clock Prescaler

This block turns a fast input clock into two clock-enable streams for a converter datapath. The internal master-clock enable is produced by three divider stages in series. The first two stages can divide by 1, 2 or 3, and the last stage can divide by 1, 2 or 4. The sample-rate strobe then fires once for every 256 of those enables. Each stage is a small counter that emits a single-cycle enable, so the rest of the chip stays on the one input clock and no derived clock net exists.

The three stage settings come in as one 6-bit value on a plain input. A setting is adopted only at a sample-strobe boundary, so every sample period runs entirely at one ratio. After reset is released, a busy flag covers a fixed initialisation window. While it is up the strobes keep running at pass-through and the configuration input is ignored.

Top module: `mclk_prescaler`

## Requirements
- R1: The first stage takes its code from cfg_i[1:0] and the second from cfg_i[3:2]. In both, code 01 divides by 2, code 10 divides by 3, and codes 00 and 11 pass every enable through (divide by 1).
- R2: The third stage takes its code from cfg_i[5:4]. Code 01 divides by 2, code 10 divides by 4, and codes 00 and 11 pass through.
- R3: imclk_en_o is a single-cycle pulse that recurs exactly every R = r1*r2*r3 input cycles, where r1, r2 and r3 are the three stage ratios.
- R4: fs_stb_o is high only in a cycle where imclk_en_o is high, and only on every 256th such pulse, so the strobe period is 256*R input cycles.
- R5: After reset all stages pass through. imclk_en_o is high in every cycle, and the first fs_stb_o appears 255 clock edges after the release.
- R6: busy_o is high during reset and for exactly 3072 rising edges after the release, then stays low until the next reset.
- R7: A strobe that occurs while busy_o is high does not load cfg_i, so the active ratio stays at pass-through.
- R8: With busy_o low, cfg_i is sampled on the edge that ends a strobe cycle. The period in progress finishes at the old ratio, and the next period runs wholly at the new one.
- R9: Setting cfg_i = 6'b00_01_10 (divide by 3, then by 2, then pass-through) gives an enable every 6 input cycles and a strobe every 1536 input cycles. With a 12.288 MHz input this is a 2.048 MHz enable and an 8 kHz strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 6 | Stage codes: [5:4] third, [3:2] second, [1:0] first |
| imclk_en_o | output | 1 | Internal master-clock enable pulse |
| fs_stb_o | output | 1 | Sample-rate strobe, one per 256 enables |
| busy_o | output | 1 | Initialisation window after reset release |

## Verification
The properties assume that cfg_i holds steady from the cycle it is sampled. They also assume that only the three stage codes matter, so the spare code 11 must act exactly like 00. The stimulus changes cfg_i only at negative edges and draws 00 or 11 at random wherever a stage is meant to pass through. It walks every ratio combination, each applied on a strobe cycle, plus one change made in the middle of a period. It also drives one configuration during the busy window to show that it is held off until a strobe after busy falls.

// File: rtl/mclk_prescaler_pkg.sv
package mclk_prescaler_pkg;

   localparam int CODE_W    = 2;
   localparam int N_STAGES  = 3;
   localparam int MAX_RATIO = 4;

   typedef logic [CODE_W-1:0] div_code_t;

endpackage

// File: rtl/mclk_div_stage.sv
module mclk_div_stage
   import mclk_prescaler_pkg::*;
#(
   parameter bit WIDE_TOP = 1'b0,
   parameter int CNT_W    = $clog2(MAX_RATIO)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  div_code_t code,
   input  logic      en_in,
   output logic      en_out
);

   if (CNT_W < 2) begin : g_bad_width
      $error("mclk_div_stage: CNT_W too small for ratio 4");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_v;

   if (WIDE_TOP) begin : g_pow2
      always_comb begin
         unique case (code)
            2'b01:   last_v = CNT_W'(1);
            2'b10:   last_v = CNT_W'(3);
            default: last_v = '0;
         endcase
      end
   end else begin : g_odd
      always_comb begin
         unique case (code)
            2'b01:   last_v = CNT_W'(1);
            2'b10:   last_v = CNT_W'(2);
            default: last_v = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_in) begin
         cnt_q <= (cnt_q == last_v) ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign en_out = en_in && (cnt_q == last_v);

endmodule

// File: rtl/mclk_fs_counter.sv
module mclk_fs_counter #(
   parameter int FS_DIV = 256,
   localparam int CW    = $clog2(FS_DIV)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_in,
   output logic stb_o
);

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q == CW'(FS_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_in) begin
         cnt_q <= at_end ? '0 : cnt_q + CW'(1);
      end
   end

   assign stb_o = en_in && at_end;

endmodule

// File: rtl/mclk_busy_timer.sv
module mclk_busy_timer #(
   parameter int CYCLES = 3072,
   localparam int CW    = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic busy_o
);

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= CW'(CYCLES);
      end else if (left_q != '0) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign busy_o = (left_q != '0);

endmodule

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
   import mclk_prescaler_pkg::*;
#(
   parameter int FS_DIV      = 256,
   parameter int BUSY_CYCLES = 3072,
   localparam int CFG_W      = N_STAGES * CODE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_i,
   output logic             imclk_en_o,
   output logic             fs_stb_o,
   output logic             busy_o
);

   if (FS_DIV < 2) begin : g_bad_fs
      $error("mclk_prescaler: FS_DIV must be at least 2");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("mclk_prescaler: BUSY_CYCLES must be at least 1");
   end

   logic [CFG_W-1:0]  act_cfg_q;
   logic [N_STAGES:0] en_chain;

   assign en_chain[0] = 1'b1;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      mclk_div_stage #(
         .WIDE_TOP (i == N_STAGES - 1)
      ) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .code   (act_cfg_q[i*CODE_W +: CODE_W]),
         .en_in  (en_chain[i]),
         .en_out (en_chain[i+1])
      );
   end

   assign imclk_en_o = en_chain[N_STAGES];

   mclk_fs_counter #(
      .FS_DIV (FS_DIV)
   ) u_fs (
      .clk   (clk),
      .rst_n (rst_n),
      .en_in (imclk_en_o),
      .stb_o (fs_stb_o)
   );

   mclk_busy_timer #(
      .CYCLES (BUSY_CYCLES)
   ) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_o (busy_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg_q <= '0;
      end else if (fs_stb_o && !busy_o) begin
         act_cfg_q <= cfg_i;
      end
   end

endmodule

// File: rtl/mclk_prescaler_chk.sv
module mclk_prescaler_chk #(
   parameter int FS_DIV      = 256,
   parameter int BUSY_CYCLES = 3072,
   parameter int CFG_W       = 6,
   localparam int EW         = $clog2(FS_DIV) + 1,
   localparam int BW         = $clog2(BUSY_CYCLES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             imclk_en,
   input logic             fs_stb,
   input logic             busy,
   input logic [CFG_W-1:0] act_cfg
);

   logic [EW-1:0] en_seen_q;
   logic [BW-1:0] since_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_seen_q <= '0;
      end else if (fs_stb) begin
         en_seen_q <= '0;
      end else if (imclk_en) begin
         en_seen_q <= en_seen_q + EW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst_q <= '0;
      end else if (since_rst_q != BW'(BUSY_CYCLES)) begin
         since_rst_q <= since_rst_q + BW'(1);
      end
   end

   // R4
   strobe_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stb |-> imclk_en);

   // R4
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_stb |-> (en_seen_q == EW'(FS_DIV - 1)));

   // R6
   busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q != BW'(BUSY_CYCLES)) |-> busy);

   // R6
   busy_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q == BW'(BUSY_CYCLES)) |-> !busy);

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_stb |=> $stable(act_cfg));

   // R7
   cfg_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(act_cfg));

endmodule

bind mclk_prescaler mclk_prescaler_chk #(
   .FS_DIV      (FS_DIV),
   .BUSY_CYCLES (BUSY_CYCLES),
   .CFG_W       (CFG_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .imclk_en (imclk_en_o),
   .fs_stb   (fs_stb_o),
   .busy     (busy_o),
   .act_cfg  (act_cfg_q)
);

// File: tb/sim_mclk_prescaler.sv
`timescale 1ns/1ps
module sim_mclk_prescaler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cfg_i = 6'b0;
   logic       imclk_en_o, fs_stb_o, busy_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   mclk_prescaler u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_i      (cfg_i),
      .imclk_en_o (imclk_en_o),
      .fs_stb_o   (fs_stb_o),
      .busy_o     (busy_o)
   );

   function automatic int ratio_ab(logic [1:0] c);
      return (c == 2'b01) ? 2 : (c == 2'b10) ? 3 : 1;
   endfunction

   function automatic int ratio_c(logic [1:0] c);
      return (c == 2'b01) ? 2 : (c == 2'b10) ? 4 : 1;
   endfunction

   function automatic int total_ratio(logic [5:0] c);
      return ratio_ab(c[1:0]) * ratio_ab(c[3:2]) * ratio_c(c[5:4]);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Starts at a negedge where fs_stb_o was high; ends at the next such negedge.
   task automatic measure(input int t_exp, output int per, output int ens, output int gap_bad);
      int last = 0;
      per = 0; ens = 0; gap_bad = 0;
      do begin
         @(negedge clk);
         per++;
         if (imclk_en_o) begin
            ens++;
            if (per - last != t_exp) gap_bad++;
            last = per;
         end
      end while (!fs_stb_o && per < 20000);
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!fs_stb_o);
   endtask

   function automatic logic [1:0] pick(int idx, bit top);
      if (idx == 0) return ($urandom % 2) ? 2'b11 : 2'b00;
      if (idx == 1) return 2'b01;
      return 2'b10;
   endfunction

   initial begin : watchdog
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : main
      int per, ens, gb, t, k, first_stb, busy_low, stb_bad, nstb, next_stb;
      logic [5:0] c;
      void'($urandom(32'h00C0FFEE));

      repeat (3) @(negedge clk);
      // R6 reset state
      check(busy_o == 1'b1, "R6 busy in reset", int'(busy_o), 1);

      // R7: this value must not load during the busy window
      cfg_i = 6'b01_01_01;
      rst_n = 1'b1;
      // R5 pass-through after release
      check(imclk_en_o == 1'b1, "R5 enable every cycle", int'(imclk_en_o), 1);
      k = 0; first_stb = -1; busy_low = -1; stb_bad = 0; nstb = 0; next_stb = -1;
      while (k < 5400) begin
         @(negedge clk);
         k++;
         if (k < 3327 && !imclk_en_o) stb_bad++;
         if (busy_low < 0 && !busy_o) busy_low = k;
         if (busy_low >= 0 && busy_o) stb_bad++;
         if (fs_stb_o) begin
            nstb++;
            if (first_stb < 0) first_stb = k;
            else if (k <= 3327 && ((k - 255) % 256) != 0) stb_bad++;
            if (k > 3327 && next_stb < 0) next_stb = k;
         end
      end
      check(first_stb == 255, "R5 first strobe", first_stb, 255);
      check(busy_low == 3072, "R6 busy release", busy_low, 3072);
      check(stb_bad == 0, "R7 pass-through kept while busy", stb_bad, 0);
      // R8: loaded at strobe k=3327, next period is 256*8
      check(next_stb == 3327 + 2048, "R8 load after busy", next_stb, 3327 + 2048);

      // R9 directed: /3, /2, /1
      cfg_i = 6'b01_01_01;
      wait_strobe();
      cfg_i = 6'b00_01_10;
      measure(6, per, ens, gb);
      check(per == 1536, "R9 strobe period", per, 1536);
      check(gb == 0, "R9 enable spacing 6", gb, 0);

      // R8: change in the middle of a period
      repeat (100) @(negedge clk);
      cfg_i = 6'b10_00_00;
      measure(6, per, ens, gb);
      check(per == 1536 - 100, "R8 old ratio completes", per, 1536 - 100);
      measure(4, per, ens, gb);
      check(per == 1024, "R8 new ratio", per, 1024);

      // R1 R2 R3 R4 all ratio combinations, random spare codes for pass-through
      for (int a = 0; a < 3; a++) begin
         for (int b = 0; b < 3; b++) begin
            for (int d = 0; d < 3; d++) begin
               c = {pick(d, 1'b1), pick(b, 1'b0), pick(a, 1'b0)};
               t = total_ratio(c);
               cfg_i = c;
               measure(t, per, ens, gb);
               check(per == 256 * t, "R1 R2 stage ratios (period)", per, 256 * t);
               check(gb == 0, "R3 enable spacing", gb, 0);
               check(ens == 256, "R4 enables per strobe", ens, 256);
            end
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule